// File: doc/BRIEF.md
# Two-Read One-Write Register File

This block holds the architectural integer registers of a small processor core. There are 32 register indices. Index 31 is a constant zero with no storage behind it. The other 31 indices each map to one storage word of `DW` bits. Two read ports return register contents combinationally from their own 5-bit indices. One write port stores data on the rising clock edge.

Writes are selective. A one-hot decode of the write index is gated by the write enable, and the result drives a per-word load enable. Every word runs on the same clock, and no clock is ever gated. A read of the register that is being written in the same cycle returns the old contents. The new value is visible after the edge. The block has no reset, so storage contents are undefined until a word is first written.

Top module: `regfile_2r1w`

## Requirements
- R1: Read port A returns, combinationally, the current contents of the register selected by `rd_a_idx`.
- R2: Read port B returns the contents selected by `rd_b_idx` independently of port A. Both ports may select the same register at the same time.
- R3: Reading index 31 on either port always returns all zeros.
- R4: When `wr_en` is 1 at a rising clock edge, the word at `wr_idx` (for indices 0 to 30) loads `wr_data`. The value is readable from the next cycle.
- R5: When `wr_en` is 0 at a clock edge, no stored word changes.
- R6: A write to index 31 changes no stored word, and index 31 still reads as zero.
- R7: A write changes only the addressed word. All other words keep their values.
- R8: A read of the register being written in the same cycle returns the old value before the edge and the new value after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all storage words |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | DW | Read port A data |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | DW | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register index |
| wr_data | input | DW | Write data |

## Verification
Read results are combinational, so a read is due in the same cycle its index is applied. The bench drives indices away from the clock edge and samples a short settle time later. A write becomes visible only after the rising edge that captures it. The bench therefore compares writes after that edge, checks the old value just before the edge for same-cycle reads, and updates its reference array at the edge.

// File: rtl/regfile_2r1w.sv
module regfile_2r1w #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic [4:0]    rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [4:0]    rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [4:0]    wr_idx,
  input  logic [DW-1:0] wr_data
);
  localparam int NREG  = 32;
  localparam int NWORD = NREG - 1;
  localparam int ZIDX  = NREG - 1;

  logic [NWORD-1:0] load;
  logic [DW-1:0]    word [NWORD];

  for (genvar i = 0; i < NWORD; i++) begin : g_word
    assign load[i] = wr_en && (wr_idx == 5'(i));
    always_ff @(posedge clk)
      if (load[i]) word[i] <= wr_data;
  end

  assign rd_a_data = (rd_a_idx == 5'(ZIDX)) ? '0 : word[rd_a_idx];
  assign rd_b_data = (rd_b_idx == 5'(ZIDX)) ? '0 : word[rd_b_idx];

  // Assertions
  always_comb begin
    if (rd_a_idx == 5'(ZIDX)) p_zero_a_r3: assert (rd_a_data == '0);
    if (rd_b_idx == 5'(ZIDX)) p_zero_b_r3: assert (rd_b_data == '0);
    p_load_onehot_r7: assert ($onehot0(load));
  end

  p_no_load_idle_r5: assert property (@(posedge clk) !wr_en |-> (load == '0));
  p_no_load_zero_r6: assert property (@(posedge clk) (wr_idx == 5'(ZIDX)) |-> (load == '0));
  p_write_lands_r4: assert property (@(posedge clk)
    (wr_en && wr_idx != 5'(ZIDX) && rd_a_idx == wr_idx) |=>
      ($stable(rd_a_idx) |-> rd_a_data == $past(wr_data)));
  p_ports_agree_r2: assert property (@(posedge clk)
    (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data || $isunknown(rd_a_data)));
endmodule

// File: tb/regfile_2r1w_tb.sv
module regfile_2r1w_tb;
  localparam int DW = 32;
  logic clk = 0;
  logic [4:0] ra, rb, wi;
  logic we;
  logic [DW-1:0] wd, qa, qb;
  logic [DW-1:0] ref_m [31];
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  regfile_2r1w #(.DW(DW)) u_dut (
    .clk(clk), .rd_a_idx(ra), .rd_a_data(qa), .rd_b_idx(rb), .rd_b_data(qb),
    .wr_en(we), .wr_idx(wi), .wr_data(wd));

  function automatic logic [DW-1:0] exp_of(input logic [4:0] i);
    return (i == 5'd31) ? '0 : ref_m[i];
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic e, input logic [4:0] i, input logic [DW-1:0] d);
    we = e; wi = i; wd = d;
    @(posedge clk);
    if (e && i != 5'd31) ref_m[i] = d;
    #1; we = 0;
  endtask

  task automatic rd_both(input logic [4:0] a, input logic [4:0] b, input string req);
    ra = a; rb = b; #0.5;
    chk(req, qa, exp_of(a));
    chk(req, qb, exp_of(b));
  endtask

  task automatic t_fill_r1_r4;
    for (int i = 0; i < 31; i++) wr(1, 5'(i), 32'hA500_0000 ^ (i * 32'h01010101));
    for (int i = 0; i < 31; i++) rd_both(5'(i), 5'(30 - i), "R1/R2/R4 fill readback");
  endtask

  task automatic t_zero_r3_r6;
    rd_both(5'd31, 5'd31, "R3 zero read");
    wr(1, 5'd31, 32'hFFFF_FFFF);
    rd_both(5'd31, 5'd0, "R6 write to 31 ignored");
    for (int i = 0; i < 31; i++) rd_both(5'(i), 5'd31, "R6 no word changed");
  endtask

  task automatic t_disabled_r5;
    wr(0, 5'd7, 32'hDEAD_BEEF);
    rd_both(5'd7, 5'd8, "R5 disabled write");
  endtask

  task automatic t_isolate_r7;
    wr(1, 5'd12, 32'h1234_5678);
    for (int i = 0; i < 31; i++) rd_both(5'(i), 5'd12, "R7 only addressed word");
  endtask

  task automatic t_same_r2;
    rd_both(5'd5, 5'd5, "R2 same register both ports");
  endtask

  task automatic t_rw_same_r8;
    logic [DW-1:0] old;
    old = ref_m[20];
    ra = 5'd20; rb = 5'd20;
    @(negedge clk);
    we = 1; wi = 5'd20; wd = ~old; #0.5;
    chk("R8 old before edge", qa, old);
    @(posedge clk); ref_m[20] = ~old; #1; we = 0;
    chk("R8 new after edge", qa, ~old);
    chk("R8 new after edge port B", qb, ~old);
  endtask

  task automatic t_random;
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      wr($urandom_range(0, 3) != 0, 5'($urandom_range(0, 31)), $urandom);
      rd_both(5'($urandom_range(0, 31)), 5'($urandom_range(0, 31)), "R4/R5/R6 random");
    end
  endtask

  initial begin
    ra = 0; rb = 0; we = 0; wi = 0; wd = 0;
    @(negedge clk);
    t_fill_r1_r4();
    t_zero_r3_r6();
    t_disabled_r5();
    t_isolate_r7();
    t_same_r2();
    t_rw_same_r8();
    t_random();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); checks++; fails++; $display("FAIL watchdog expired"); end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule